// File: doc/BRIEF.md
# Five-Wire Serial Programming Controller

This block is the device-side end of a five-pin in-system programming port. An active-low enable decides what four shared pins are. While the enable is high they are plain dedicated inputs and go straight through to the core logic. While it is low a small sequencer takes them over. Its serial clock, mode and data pins load a 5-bit instruction, shift a one-hot row-address register and a two-half data register, and run commands against a behavioural configuration array. The commands are program row, verify row and read identifier.

The host presents mode and data, then raises the serial clock. A rising edge with mode low shifts one bit. A rising edge with mode high moves the sequencer, and the data pin chooses where it goes. The block drives serial data out after each falling edge, so the host samples it on the next rising edge. All pins are sampled into the system clock domain by synchronisers. Writing a row is an immediate array write: the high-voltage timing of a real non-volatile cell is not modelled. Row count and data width are parameters, so simulation can use a small array.

Top module: `isp_serial_ctrl`

## Requirements
- R1: While `prog_en_n` is high, `core_din` equals {`pin_sclk`, `pin_sdo_in`, `pin_mode`, `pin_sdi`} (bit 3 down to bit 0) and `sdo_oe` is 0. Once the synchronised enable is low, `core_din` is 0 and `sdo_oe` is 1.
- R2: After reset, `sdo_out` is 0, the sequencer is idle, and every array row reads back as all zeros.
- R3: Sequencer behaviour depends on the state and on a rising serial clock.
  - Idle, mode low: the edge shifts `pin_sdi` into the instruction register, so the first bit sent becomes bit 0.
  - Idle, mode high: data 1 enters shift and data 0 enters execute.
  - Shift, mode high: data 1 enters execute and data 0 returns to idle.
  - Execute lasts one system clock and then returns to idle.
  - A mode-high edge never shifts any register.
- R4: Instruction codes: 0 selects the address register for shifting, 1 the data register, 2 programs, 3 verifies and 4 reads the identifier. Other codes do nothing.
- R5: In shift state with instruction 0, each mode-low rising edge moves the ROWS-bit address register one place toward bit 0. `pin_sdi` enters bit ROWS-1, and the serial output shows bit 0. A 1 in bit r selects row r.
- R6: The data register is made of a high half and a low half of DW/2 bits each. With instruction 1, `pin_sdi` enters the top of the high half, the bottom of the high half feeds the top of the low half, and the serial output shows bit 0 of the low half. Shifting DW bits with the LSB first therefore loads the word and returns the previous word LSB first.
- R7: Executing instruction 4 loads 8'b0000_0011 into data bits 7:0 and clears all other data bits.
- R8: Executing instruction 2 writes the data register into every row whose address bit is 1. Rows whose address bit is 0 keep their contents.
- R9: Executing instruction 3 loads the lowest-numbered selected row into the data register. If no address bit is set, it loads zero.
- R10: `sdo_out` changes only in the system clock after a synchronised falling serial clock. It holds through the high phase of the serial clock.
- R11: Raising the enable returns the sequencer to idle and leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prog_en_n | input | 1 | Active-low programming enable |
| pin_sdi | input | 1 | Serial data in / dedicated input 0 |
| pin_mode | input | 1 | Mode / dedicated input 1 |
| pin_sdo_in | input | 1 | Serial-out pin sensed as dedicated input 2 |
| pin_sclk | input | 1 | Serial clock / dedicated input 3 |
| core_din | output | 4 | Shared pins passed to the core logic |
| sdo_out | output | 1 | Serial data out value |
| sdo_oe | output | 1 | Output enable for the serial-out pin |

## Verification
A mode-high rising serial clock in shift state is both a candidate shift edge and a state change. Only the state change may take effect. The bench provokes this case after every shift burst and again inside the identifier, address and data sequences. It judges the result by reading the register back bit for bit: any stray shift shows up as a one-place offset in the returned word. A second overlap is the release of the enable while the sequencer sits in shift. The bench judges it by whether the following instruction-load edges disturb the data register.

// File: rtl/isp_pkg.sv
package isp_pkg;
   localparam int OP_W = 5;
   localparam int ID_W = 8;
   localparam logic [ID_W-1:0] ISP_ID_CODE = 8'b0000_0011;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_EXEC  = 2'd2
   } isp_state_e;

   localparam logic [OP_W-1:0] OP_ADDR = 5'd0;
   localparam logic [OP_W-1:0] OP_DATA = 5'd1;
   localparam logic [OP_W-1:0] OP_PROG = 5'd2;
   localparam logic [OP_W-1:0] OP_VFY  = 5'd3;
   localparam logic [OP_W-1:0] OP_RDID = 5'd4;
endpackage

// File: rtl/isp_pin_sync.sv
module isp_pin_sync #(
   parameter int W = 4,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("isp_pin_sync: STAGES must be at least 2");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL[b]}};
         else        chain_q <= {chain_q[STAGES-2:0], d_in[b]};
      end
      assign q_out[b] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/isp_seq.sv
module isp_seq
   import isp_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prog_act,
   input  logic            sclk_s,
   input  logic            mode_s,
   input  logic            sdi_s,
   output isp_state_e      state_q,
   output logic [OP_W-1:0] instr_q,
   output logic            sclk_rise,
   output logic            sclk_fall,
   output logic            shift_addr,
   output logic            shift_data,
   output logic            wr_en,
   output logic            rd_en,
   output logic            id_en
);
   logic sclk_d;
   logic step_lo;
   logic step_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sclk_fall = ~sclk_s & sclk_d;
   assign step_lo   = prog_act & sclk_rise & ~mode_s;
   assign step_hi   = prog_act & sclk_rise & mode_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         instr_q <= '0;
      end else if (!prog_act) begin
         state_q <= ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (step_hi)      state_q <= sdi_s ? ST_SHIFT : ST_EXEC;
               else if (step_lo) instr_q <= {sdi_s, instr_q[OP_W-1:1]};
            end
            ST_SHIFT: begin
               if (step_hi) state_q <= sdi_s ? ST_EXEC : ST_IDLE;
            end
            ST_EXEC:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign shift_addr = step_lo && (state_q == ST_SHIFT) && (instr_q == OP_ADDR);
   assign shift_data = step_lo && (state_q == ST_SHIFT) && (instr_q == OP_DATA);
   assign wr_en      = prog_act && (state_q == ST_EXEC) && (instr_q == OP_PROG);
   assign rd_en      = prog_act && (state_q == ST_EXEC) && (instr_q == OP_VFY);
   assign id_en      = prog_act && (state_q == ST_EXEC) && (instr_q == OP_RDID);
endmodule

// File: rtl/isp_shift_path.sv
module isp_shift_path
   import isp_pkg::*;
#(
   parameter int ROWS = 108,
   parameter int DW   = 320
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            prog_act,
   input  logic            sdi_s,
   input  logic            sclk_fall,
   input  logic [OP_W-1:0] instr_q,
   input  logic            shift_addr,
   input  logic            shift_data,
   input  logic            rd_en,
   input  logic            id_en,
   input  logic [DW-1:0]   rd_row,
   output logic [ROWS-1:0] addr_q,
   output logic [DW-1:0]   data_w,
   output logic            sdo_q
);
   localparam int HALF = DW / 2;

   logic [HALF-1:0] hi_q;
   logic [HALF-1:0] lo_q;
   logic            sel_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr_q <= '0;
      else if (shift_addr) addr_q <= {sdi_s, addr_q[ROWS-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (shift_data) begin
         hi_q <= {sdi_s, hi_q[HALF-1:1]};
         lo_q <= {hi_q[0], lo_q[HALF-1:1]};
      end else if (rd_en) begin
         {hi_q, lo_q} <= rd_row;
      end else if (id_en) begin
         hi_q <= '0;
         lo_q <= {{(HALF-ID_W){1'b0}}, ISP_ID_CODE};
      end
   end

   assign data_w = {hi_q, lo_q};

   always_comb begin
      unique case (instr_q)
         OP_ADDR: sel_bit = addr_q[0];
         OP_DATA: sel_bit = lo_q[0];
         default: sel_bit = instr_q[0];
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         sdo_q <= 1'b0;
      else if (!prog_act) sdo_q <= 1'b0;
      else if (sclk_fall) sdo_q <= sel_bit;
   end
endmodule

// File: rtl/isp_cfg_array.sv
module isp_cfg_array #(
   parameter int ROWS = 108,
   parameter int DW   = 320
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [ROWS-1:0] row_sel,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata
);
   logic [DW-1:0] rows_q [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   rows_q[r] <= '0;
         else if (wr_en && row_sel[r]) rows_q[r] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int r = ROWS - 1; r >= 0; r--) begin
         if (row_sel[r]) rdata = rows_q[r];
      end
   end
endmodule

// File: rtl/isp_serial_ctrl.sv
module isp_serial_ctrl
   import isp_pkg::*;
#(
   parameter int ROWS        = 108,
   parameter int DW          = 320,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       prog_en_n,
   input  logic       pin_sdi,
   input  logic       pin_mode,
   input  logic       pin_sdo_in,
   input  logic       pin_sclk,
   output logic [3:0] core_din,
   output logic       sdo_out,
   output logic       sdo_oe
);
   if (DW < 2 * ID_W || (DW % 2) != 0) begin : g_bad_dw
      $error("isp_serial_ctrl: DW must be even and at least twice the identifier width");
   end
   if (ROWS < 1) begin : g_bad_rows
      $error("isp_serial_ctrl: ROWS must be at least 1");
   end

   logic [3:0]      pins_s;
   logic            prog_act;
   isp_state_e      state_q;
   logic [OP_W-1:0] instr_q;
   logic            sclk_rise;
   logic            sclk_fall;
   logic            shift_addr;
   logic            shift_data;
   logic            wr_en;
   logic            rd_en;
   logic            id_en;
   logic [ROWS-1:0] addr_q;
   logic [DW-1:0]   data_w;
   logic [DW-1:0]   rd_row;
   logic            sdo_q;

   // bit 3 enable, 2 sclk, 1 mode, 0 sdi
   isp_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({prog_en_n, pin_sclk, pin_mode, pin_sdi}),
      .q_out (pins_s)
   );

   assign prog_act = ~pins_s[3];

   isp_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_act   (prog_act),
      .sclk_s     (pins_s[2]),
      .mode_s     (pins_s[1]),
      .sdi_s      (pins_s[0]),
      .state_q    (state_q),
      .instr_q    (instr_q),
      .sclk_rise  (sclk_rise),
      .sclk_fall  (sclk_fall),
      .shift_addr (shift_addr),
      .shift_data (shift_data),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .id_en      (id_en)
   );

   isp_shift_path #(.ROWS(ROWS), .DW(DW)) u_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_act   (prog_act),
      .sdi_s      (pins_s[0]),
      .sclk_fall  (sclk_fall),
      .instr_q    (instr_q),
      .shift_addr (shift_addr),
      .shift_data (shift_data),
      .rd_en      (rd_en),
      .id_en      (id_en),
      .rd_row     (rd_row),
      .addr_q     (addr_q),
      .data_w     (data_w),
      .sdo_q      (sdo_q)
   );

   isp_cfg_array #(.ROWS(ROWS), .DW(DW)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .row_sel (addr_q),
      .wdata   (data_w),
      .rdata   (rd_row)
   );

   assign core_din = prog_en_n ? {pin_sclk, pin_sdo_in, pin_mode, pin_sdi} : 4'b0000;
   assign sdo_out  = sdo_q;
   assign sdo_oe   = prog_act;
endmodule

// File: rtl/isp_serial_ctrl_chk.sv
module isp_serial_ctrl_chk
   import isp_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            prog_act,
   input logic            sclk_rise,
   input logic            sclk_fall,
   input logic            sdo_out,
   input isp_state_e      state_q,
   input logic [OP_W-1:0] instr_q,
   input logic            wr_en,
   input logic            rd_en,
   input logic            id_en
);
   a_r3_exec_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_EXEC |=> state_q == ST_IDLE);

   a_r3_no_move_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_act && !sclk_rise && state_q != ST_EXEC) |=> $stable(state_q));

   a_r11_release_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_act |=> state_q == ST_IDLE);

   a_r10_sdo_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_act && !sclk_fall) |=> $stable(sdo_out));

   a_r4_one_command: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_en, rd_en, id_en}));

   a_r8_write_from_exec: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (state_q == ST_EXEC && instr_q == OP_PROG));
endmodule

bind isp_serial_ctrl isp_serial_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .prog_act  (prog_act),
   .sclk_rise (sclk_rise),
   .sclk_fall (sclk_fall),
   .sdo_out   (sdo_out),
   .state_q   (state_q),
   .instr_q   (instr_q),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .id_en     (id_en)
);

// File: tb/isp_serial_ctrl_tb.sv
module isp_serial_ctrl_tb;
   localparam int ROWS = 8;
   localparam int DW   = 16;
   localparam int PH   = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       prog_en_n = 1'b1;
   logic       pin_sdi = 1'b0;
   logic       pin_mode = 1'b0;
   logic       pin_sdo_in = 1'b0;
   logic       pin_sclk = 1'b0;
   logic [3:0] core_din;
   logic       sdo_out;
   logic       sdo_oe;

   int n_checks = 0;
   int n_fails  = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   isp_serial_ctrl #(.ROWS(ROWS), .DW(DW)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .prog_en_n  (prog_en_n),
      .pin_sdi    (pin_sdi),
      .pin_mode   (pin_mode),
      .pin_sdo_in (pin_sdo_in),
      .pin_sclk   (pin_sclk),
      .core_din   (core_din),
      .sdo_out    (sdo_out),
      .sdo_oe     (sdo_oe)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one serial clock period; returns sdo seen just before the rising edge
   task automatic pulse(input logic m, input logic d, output logic so);
      logic hi_val;
      pin_mode = m;
      pin_sdi  = d;
      wait_neg(PH);
      so = sdo_out;
      pin_sclk = 1'b1;
      wait_neg(PH);
      hi_val = sdo_out;
      check("R10 sdo stable in high phase", {31'd0, hi_val}, {31'd0, so});
      pin_sclk = 1'b0;
      wait_neg(PH);
   endtask

   task automatic load_op(input logic [4:0] op);
      logic b;
      for (int i = 0; i < 5; i++) pulse(1'b0, op[i], b);
   endtask

   task automatic shift_word(input int n, input logic [31:0] win, output logic [31:0] wout);
      logic b;
      wout = '0;
      for (int i = 0; i < n; i++) begin
         pulse(1'b0, win[i], b);
         wout[i] = b;
      end
   endtask

   task automatic xfer(input logic [4:0] op, input int n, input logic [31:0] win,
                       output logic [31:0] wout);
      logic b;
      load_op(op);
      pulse(1'b1, 1'b1, b);   // idle -> shift
      shift_word(n, win, wout);
      pulse(1'b1, 1'b0, b);   // shift -> idle, must not shift
   endtask

   task automatic run_op(input logic [4:0] op);
      logic b;
      load_op(op);
      pulse(1'b1, 1'b0, b);   // idle -> exec
      wait_neg(2);
   endtask

   task automatic verify_row(input logic [7:0] sel, output logic [31:0] w);
      logic [31:0] junk;
      xfer(5'd0, ROWS, {24'd0, sel}, junk);
      run_op(5'd3);
      xfer(5'd1, DW, 32'd0, w);
   endtask

   task automatic t_reset();
      check("R2 sdo after reset", {31'd0, sdo_out}, 32'd0);
      check("R1 oe low with enable high", {31'd0, sdo_oe}, 32'd0);
   endtask

   task automatic t_passthrough();
      logic [3:0] pats [4] = '{4'b0101, 4'b1010, 4'b1111, 4'b0011};
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         {pin_sclk, pin_sdo_in, pin_mode, pin_sdi} = pats[k];
         #1;
         check("R1 core_din mirrors pins", {28'd0, core_din}, {28'd0, pats[k]});
      end
      @(negedge clk);
      {pin_sclk, pin_sdo_in, pin_mode, pin_sdi} = 4'b0000;
      prog_en_n = 1'b0;
      pin_sdo_in = 1'b1;
      pin_mode = 1'b1;
      wait_neg(4);
      check("R1 core_din gated in programming", {28'd0, core_din}, 32'd0);
      check("R1 oe high in programming", {31'd0, sdo_oe}, 32'd1);
      pin_sdo_in = 1'b0;
      pin_mode = 1'b0;
   endtask

   task automatic t_read_id();
      logic [31:0] w;
      run_op(5'd4);
      xfer(5'd1, DW, 32'd0, w);
      check("R7 identifier readout", w, 32'h0000_0003);
   endtask

   task automatic t_addr_loop();
      logic [31:0] w;
      xfer(5'd0, ROWS, 32'h0000_0004, w);
      xfer(5'd0, ROWS, 32'h0000_0004, w);
      check("R5 address readback", w, 32'h0000_0004);
   endtask

   task automatic t_mode_edge();
      logic [31:0] w;
      xfer(5'd1, DW, 32'h0000_9C31, w);
      xfer(5'd1, DW, 32'h0000_A5C3, w);
      check("R3 mode-high edges do not shift", w, 32'h0000_9C31);
      xfer(5'd1, DW, 32'h0000_A5C3, w);
      check("R6 data word returns LSB first", w, 32'h0000_A5C3);
   endtask

   task automatic t_prog_verify();
      logic [31:0] w;
      // address holds row 2, data holds A5C3
      run_op(5'd2);
      xfer(5'd1, DW, 32'd0, w);
      verify_row(8'h04, w);
      check("R8 R9 program-verify round trip", w, 32'h0000_A5C3);
      verify_row(8'h01, w);
      check("R2 unwritten row reads zero", w, 32'd0);
   endtask

   task automatic t_multi_row();
      logic [31:0] w;
      xfer(5'd0, ROWS, 32'h0000_0022, w);
      xfer(5'd1, DW, 32'h0000_1234, w);
      run_op(5'd2);
      verify_row(8'h20, w);
      check("R8 row 5 written", w, 32'h0000_1234);
      verify_row(8'h02, w);
      check("R8 row 1 written", w, 32'h0000_1234);
      verify_row(8'h04, w);
      check("R8 unselected row kept", w, 32'h0000_A5C3);
      verify_row(8'h24, w);
      check("R9 lowest selected row wins", w, 32'h0000_A5C3);
      verify_row(8'h00, w);
      check("R9 no row selected loads zero", w, 32'd0);
      run_op(5'd7);
      xfer(5'd1, DW, 32'd0, w);
      check("R4 unknown code leaves data", w, 32'd0);
   endtask

   task automatic t_release();
      logic [31:0] w;
      logic b;
      load_op(5'd1);
      pulse(1'b1, 1'b1, b);
      shift_word(DW, 32'h0000_5A5A, w);
      @(negedge clk);
      prog_en_n = 1'b1;
      pin_mode = 1'b1;
      pin_sdo_in = 1'b1;
      pin_sdi = 1'b0;
      wait_neg(4);
      check("R1 oe low after release", {31'd0, sdo_oe}, 32'd0);
      check("R1 core_din after release", {28'd0, core_din}, 32'h0000_0006);
      check("R11 sdo cleared after release", {31'd0, sdo_out}, 32'd0);
      pin_mode = 1'b0;
      pin_sdo_in = 1'b0;
      prog_en_n = 1'b0;
      wait_neg(4);
      xfer(5'd1, DW, 32'd0, w);
      check("R11 sequencer idle after release", w, 32'h0000_5A5A);
      verify_row(8'h04, w);
      check("R11 array retained", w, 32'h0000_A5C3);
   endtask

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(2);
      t_reset();
      t_passthrough();
      t_read_id();
      t_addr_loop();
      t_mode_edge();
      t_prog_verify();
      t_multi_row();
      t_release();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule